// File: doc/BRIEF.md
# Prescaled 8-bit PWM Channel

This block produces one pulse-width-modulated output from a single 32-bit control word. The input clock is divided by an 8-bit reload value to produce ticks. An 8-bit phase counter advances once per tick, so every output period lasts 256 ticks. The duty field gives the number of ticks in each period during which the output stays low. For the remaining ticks of the period the output is high. A reload value of zero selects division by 256.

A small controller with two states orders the work. `ST_IDLE` holds the prescaler and the phase counter at zero and drives the programmed idle level. The transition *start* (enable seen set) moves to `ST_RUN`, which copies the reload and duty fields into active copies and restarts counting from phase zero. The transition *stop* (enable seen clear) returns to `ST_IDLE`. While in `ST_RUN`, the reload and duty values that software writes take effect only when the phase counter wraps from 255 back to 0, so no period is cut short or stretched. Software writes the whole word and can read it back at any time.

Top module: `pwm8_channel`

## Requirements
- R1: After reset, the read-back word is 0 and `pwm_out` is low.
- R2: While the channel is disabled (bit 31 = 0), `pwm_out` equals bit 30 (idle level). It does so from the second clock edge after a write that clears bit 31.
- R3: The divider is given by bits 15:8 (reload). Values 1..255 produce one tick every `reload` clocks. Value 0 produces one tick every 256 clocks. One period lasts 256 × divider clocks.
- R4: With duty `d` in bits 7:0 and divider `D`, each period is low for `d·D` clocks and then high for `(256−d)·D` clocks.
- R5: A write to reload or duty while the channel runs leaves the current period unchanged. The new values govern from the next period on.
- R6: A write that sets bit 31 while the channel is idle restarts at phase 0 with a cleared prescaler. With idle level 0, `pwm_out` stays low for `d·D+1` clocks after the write edge and then rises.
- R7: Bits 31, 30 and 15:0 read back as last written. Bits 29:16 always read as 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the middle of a running period. The stimulus must show that the old duty and divider still finish that period. To get there, the bench first waits for a rising edge of the output, which marks phase `d` of a known configuration. It then writes a new duty and reload on the very next cycle. Next, it counts the rest of the high time, which must still follow the old duty. Finally, it measures the following low and high times, which must follow the new values.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned LVL_BIT = 30;
    localparam int unsigned RLD_LSB = 8;
    localparam int unsigned DUT_LSB = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic               en;
        logic               idle_lvl;
        logic [FIELD_W-1:0] reload;
        logic [FIELD_W-1:0] duty;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm8_cfg_reg.sv
module pwm8_cfg_reg
    import pwm8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output pwm_cfg_t          cfg,
    output logic [WORD_W-1:0] rdata
);
    pwm_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.en       <= wdata[EN_BIT];
            cfg_q.idle_lvl <= wdata[LVL_BIT];
            cfg_q.reload   <= wdata[RLD_LSB +: FIELD_W];
            cfg_q.duty     <= wdata[DUT_LSB +: FIELD_W];
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[EN_BIT]              = cfg_q.en;
        rdata[LVL_BIT]             = cfg_q.idle_lvl;
        rdata[RLD_LSB +: FIELD_W]  = cfg_q.reload;
        rdata[DUT_LSB +: FIELD_W]  = cfg_q.duty;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
    import pwm8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [FIELD_W-1:0] reload_act,
    output logic               tick
);
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] term;

    // reload 0 wraps to all-ones, giving a divide by 2**FIELD_W
    assign term = reload_act - FIELD_W'(1);
    assign tick = run && (cnt_q == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + FIELD_W'(1);
        end
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= term)); // R3
    AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/pwm8_phase_fsm.sv
module pwm8_phase_fsm
    import pwm8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  pwm_cfg_t           cfg,
    input  logic               tick,
    output logic               run,
    output logic [FIELD_W-1:0] reload_act,
    output logic               pwm_out
);
    localparam logic [FIELD_W-1:0] PHASE_LAST = '1;

    run_state_e         state_q, state_d;
    logic [FIELD_W-1:0] phase_q;
    logic [FIELD_W-1:0] duty_act_q;
    logic [FIELD_W-1:0] reload_act_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg.en)  state_d = ST_RUN;   // start
            ST_RUN:  if (!cfg.en) state_d = ST_IDLE;  // stop
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q      <= '0;
            duty_act_q   <= '0;
            reload_act_q <= '0;
        end else if (state_q == ST_IDLE) begin
            phase_q <= '0;
            if (cfg.en) begin
                duty_act_q   <= cfg.duty;
                reload_act_q <= cfg.reload;
            end
        end else if (tick) begin
            phase_q <= phase_q + FIELD_W'(1);
            if (phase_q == PHASE_LAST) begin
                duty_act_q   <= cfg.duty;
                reload_act_q <= cfg.reload;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: pwm_out = cfg.idle_lvl;
            ST_RUN:  pwm_out = (phase_q >= duty_act_q);
            default: pwm_out = cfg.idle_lvl;
        endcase
    end

    assign run        = (state_q == ST_RUN);
    assign reload_act = reload_act_q;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && $past(!cfg.en)) |-> (pwm_out == cfg.idle_lvl)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (phase_q != $past(phase_q))) |-> (phase_q == $past(phase_q) + FIELD_W'(1))); // R4
    AST_LATCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(duty_act_q)) |-> ($past(phase_q) == PHASE_LAST)); // R5
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (phase_q == '0)); // R6
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
    import pwm8_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pwm_out
);
    pwm_cfg_t           cfg;
    logic               run;
    logic               tick;
    logic [FIELD_W-1:0] reload_act;

    pwm8_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    pwm8_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .reload_act (reload_act),
        .tick       (tick)
    );

    pwm8_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .tick       (tick),
        .run        (run),
        .reload_act (reload_act),
        .pwm_out    (pwm_out)
    );

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we) |-> (reg_rdata[29:16] == '0)); // R7
endmodule

// File: tb/pwm8_channel_tb.sv
module pwm8_channel_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WD_LIMIT   = 190000;
    localparam int  NVEC       = 6;
    // each entry: {reload, duty}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h01_80, 16'h02_01, 16'h03_FF, 16'h05_28, 16'h00_01, 16'h01_40
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    pwm8_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // call at a negedge; returns at the next negedge
    task automatic wr(input logic [31:0] v);
        reg_we = 1; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl && cyc < WD_LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo1, hi, lo2, d, dv, n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rdata after reset", reg_rdata, 0);
        chk("R1 pwm_out after reset", pwm_out, 0);

        // vector table: restart, divider and duty timing
        for (int i = 0; i < NVEC; i++) begin
            dv = (VEC[i][15:8] == 0) ? 256 : VEC[i][15:8];
            d  = VEC[i][7:0];
            wr(32'h0000_0000);
            repeat (2) @(negedge clk);
            wr({1'b1, 1'b0, 14'd0, VEC[i]});
            count_level(1'b0, lo1);
            count_level(1'b1, hi);
            count_level(1'b0, lo2);
            chk($sformatf("R6 first low vec%0d", i), lo1, d*dv + 1);
            chk($sformatf("R4 high time vec%0d", i), hi, (256-d)*dv);
            chk($sformatf("R3 R4 low time vec%0d", i), lo2, d*dv);
        end

        // R5: last vector leaves reload 1 duty 64, now at first high negedge
        wr({1'b1, 1'b0, 14'd0, 8'h02, 8'hC8});
        count_level(1'b1, hi);
        chk("R5 rest of period keeps old duty", hi, 191);
        count_level(1'b0, lo2);
        chk("R5 next low uses new duty and reload", lo2, 400);
        count_level(1'b1, hi);
        chk("R5 next high uses new values", hi, 112);

        // R2: disable with idle level 1
        wr(32'h4000_0000);
        @(negedge clk);
        chk("R2 idle level high", pwm_out, 1);
        n = 0;
        for (int k = 0; k < 300; k++) begin
            if (pwm_out != 1'b1) n++;
            @(negedge clk);
        end
        chk("R2 idle level held", n, 0);
        wr(32'h0000_0000);
        chk("R2 idle level low", pwm_out, 0);

        // R7: readback masking
        wr(32'hFFFF_FFFF);
        chk("R7 readback all ones", reg_rdata, 32'hC000_FFFF);
        wr(32'h3FFF_0000);
        chk("R7 reserved bits read zero", reg_rdata, 0);
        repeat (2) @(negedge clk);
        chk("R2 disabled after reserved write", pwm_out, 0);

        if (cyc >= WD_LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule